// File: doc/BRIEF.md
# Security Region Program Guard

This block holds a 1024-byte write-once security area and decides, for every program request, whether the write may land. The area is split into 32 aligned slices of 32 bytes. The first slice carries three things: a 16-byte factory identifier that users may not change, a 4-byte lock field with one bit per slice, and 12 spare bytes that the host may program freely.

A program request carries a byte address and a data byte. The guard first checks the global write-open input. It then checks whether the write would clear an identifier bit, and finally checks the lock bit of the target slice. An accepted write can only clear bits, because the new value is the old byte ANDed with the request data. The area has no erase. Every request is answered one cycle later by a done pulse and a fail status bit.

When the global write-open input is low, the request is dropped without any error indication. A read port returns any stored byte one cycle after its strobe. On both ports, address bits above the 10-bit offset are ignored.

Top module: `sec_otp_guard`

## Requirements
- R1: After reset, bytes 0x000-0x00F hold the FACTORY_ID parameter, with byte i taken from bits [8i+7:8i]. Every other byte reads 0xFF, and prog_done, prog_err and rd_valid are 0.
- R2: An accepted program replaces byte M with M AND prog_data. prog_done is high in exactly the cycle after prog_req, and prog_err is 0 in that cycle.
- R3: The same address may be programmed repeatedly, and each program further ANDs the stored value. No bit ever returns from 0 to 1.
- R4: A program to offsets 0x000-0x00F that would clear any stored 1 bit is refused. The byte is unchanged and prog_err reads 1. A program that clears no bit there is accepted with prog_err 0.
- R5: Bit j of byte 0x010+k is the lock bit of slice 8k+j, where the slice number is offset bits [9:5]. While that bit is 0, a program into the slice leaves it unchanged and sets prog_err to 1.
- R6: The lock bytes 0x010-0x013 and the spare bytes 0x014-0x01F are programmable like user bytes while slice 0 is unlocked.
- R7: While wr_open is 0, a program changes no byte. prog_done still pulses and prog_err reads 0.
- R8: Address bits 10 and above are ignored on both ports, so an address wraps onto offset addr[9:0].
- R9: rd_data shows the byte at rd_addr in the cycle after rd_req, with rd_valid high in that cycle only.
- R10: The wr_open check takes priority. A closed program aimed at identifier bytes or at a locked slice still reports prog_err 0.
- R11: prog_err keeps the result of the latest program until the next program is answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads the delivery contents |
| wr_open | input | 1 | 1 permits programming; 0 drops programs silently |
| prog_req | input | 1 | Program strobe, one cycle per request |
| prog_addr | input | ADDR_W | Program byte address (bits 9:0 used) |
| prog_data | input | 8 | Program data; bits at 0 clear stored bits |
| rd_req | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read byte address (bits 9:0 used) |
| prog_done | output | 1 | Pulses in the cycle after each program request |
| prog_err | output | 1 | 1 when the latest program was refused |
| rd_valid | output | 1 | Pulses in the cycle after each read strobe |
| rd_data | output | 8 | Byte read |

## Verification
A wrong lock or identifier decision shows up on prog_err in the cycle after the request. Any write that slipped through, or any byte left untouched when it should have changed, appears on rd_data at the next read of that offset, which comes two cycles later. A lock field decoded to the wrong slice only shows up when that slice is hit, so the bench locks slices at both ends of the field and probes every slice. A wrap fault shows up when an aliased address reads back a byte other than the one its low bits name.

// File: rtl/sec_otp_pkg.sv
package sec_otp_pkg;
    localparam int unsigned REGION_BYTES = 32;
    localparam int unsigned NUM_REGIONS  = 32;
    localparam int unsigned SPACE_BYTES  = REGION_BYTES * NUM_REGIONS;
    localparam int unsigned OFS_W        = $clog2(SPACE_BYTES);
    localparam int unsigned SUB_W        = $clog2(REGION_BYTES);
    localparam int unsigned REG_W        = $clog2(NUM_REGIONS);
    localparam int unsigned FACT_BYTES   = 16;
    localparam int unsigned LOCK_BASE    = 16;
    localparam int unsigned LOCK_BYTES   = NUM_REGIONS / 8;

    typedef logic [OFS_W-1:0] ofs_t;
    typedef logic [7:0]       byte_t;

    typedef enum logic [1:0] {
        V_WRITE  = 2'd0,
        V_SILENT = 2'd1,
        V_REJECT = 2'd2
    } verdict_t;

    typedef struct packed {
        ofs_t  ofs;
        byte_t data;
    } prog_cmd_t;

    function automatic logic [REG_W-1:0] region_of(ofs_t o);
        return o[OFS_W-1:SUB_W];
    endfunction

    function automatic ofs_t lock_byte_of(ofs_t o);
        logic [REG_W-1:0] r;
        r = region_of(o);
        return ofs_t'(LOCK_BASE) + ofs_t'(r >> 3);
    endfunction

    function automatic logic [2:0] lock_bit_of(ofs_t o);
        logic [REG_W-1:0] r;
        r = region_of(o);
        return r[2:0];
    endfunction
endpackage

// File: rtl/sec_otp_policy.sv
module sec_otp_policy
    import sec_otp_pkg::*;
(
    input  logic      wr_open,
    input  prog_cmd_t cmd,
    input  byte_t     old_byte,
    input  byte_t     lock_byte,
    output verdict_t  verdict,
    output byte_t     merged
);
    logic clears_bit;
    logic in_factory;
    logic locked;

    assign clears_bit = (old_byte & ~cmd.data) != 8'h00;
    assign in_factory = cmd.ofs < ofs_t'(FACT_BYTES);
    assign locked     = !lock_byte[lock_bit_of(cmd.ofs)];
    assign merged     = old_byte & cmd.data;

    always_comb begin
        if (!wr_open)
            verdict = V_SILENT;
        else if (in_factory && clears_bit)
            verdict = V_REJECT;
        else if (locked)
            verdict = V_REJECT;
        else
            verdict = V_WRITE;
    end
endmodule

// File: rtl/sec_otp_store.sv
module sec_otp_store
    import sec_otp_pkg::*;
#(
    parameter logic [8*FACT_BYTES-1:0] FACTORY_ID = '0
) (
    input  logic  clk,
    input  logic  rst,
    input  ofs_t  pa,
    output byte_t old_q,
    input  ofs_t  la,
    output byte_t lock_q,
    input  logic  we,
    input  byte_t wdata,
    input  logic  re,
    input  ofs_t  ra,
    output byte_t rdata
);
    byte_t mem [SPACE_BYTES];

    assign old_q  = mem[pa];
    assign lock_q = mem[la];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int unsigned i = 0; i < FACT_BYTES; i++)
                mem[i] <= FACTORY_ID[8*i +: 8];
            for (int unsigned i = FACT_BYTES; i < SPACE_BYTES; i++)
                mem[i] <= 8'hFF;
        end else if (we) begin
            mem[pa] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= 8'h00;
        else if (re)
            rdata <= mem[ra];
    end
endmodule

// File: rtl/sec_otp_guard.sv
module sec_otp_guard
    import sec_otp_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter logic [8*FACT_BYTES-1:0] FACTORY_ID = 128'h1122_3344_5566_7788_99AA_BBCC_DDEE_F1F2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_open,
    input  logic              prog_req,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [7:0]        prog_data,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              prog_done,
    output logic              prog_err,
    output logic              rd_valid,
    output logic [7:0]        rd_data
);
    prog_cmd_t cmd;
    byte_t     old_byte;
    byte_t     lock_byte;
    byte_t     wr_byte;
    verdict_t  verdict;
    logic      wr_en;

    assign cmd.ofs  = prog_addr[OFS_W-1:0];
    assign cmd.data = prog_data;
    assign wr_en    = prog_req && (verdict == V_WRITE);

    sec_otp_policy i_policy (
        .wr_open   (wr_open),
        .cmd       (cmd),
        .old_byte  (old_byte),
        .lock_byte (lock_byte),
        .verdict   (verdict),
        .merged    (wr_byte)
    );

    sec_otp_store #(.FACTORY_ID(FACTORY_ID)) i_store (
        .clk    (clk),
        .rst    (rst),
        .pa     (cmd.ofs),
        .old_q  (old_byte),
        .la     (lock_byte_of(cmd.ofs)),
        .lock_q (lock_byte),
        .we     (wr_en),
        .wdata  (wr_byte),
        .re     (rd_req),
        .ra     (rd_addr[OFS_W-1:0]),
        .rdata  (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_done <= 1'b0;
            prog_err  <= 1'b0;
            rd_valid  <= 1'b0;
        end else begin
            prog_done <= prog_req;
            rd_valid  <= rd_req;
            if (prog_req)
                prog_err <= (verdict == V_REJECT);
        end
    end
endmodule

// File: rtl/sec_otp_guard_chk.sv
module sec_otp_guard_chk
    import sec_otp_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_open,
    input logic              prog_req,
    input logic [ADDR_W-1:0] prog_addr,
    input logic [7:0]        prog_data,
    input logic              rd_req,
    input logic              prog_done,
    input logic              prog_err,
    input logic              rd_valid,
    input logic [7:0]        old_byte,
    input logic [7:0]        lock_byte
);
    p_done_after_req_r2: assert property (@(posedge clk) disable iff (rst)
        prog_req |=> prog_done);

    p_no_spurious_done_r2: assert property (@(posedge clk) disable iff (rst)
        !prog_req |=> !prog_done);

    p_factory_refused_r4: assert property (@(posedge clk) disable iff (rst)
        (prog_req && wr_open && (prog_addr[OFS_W-1:0] < ofs_t'(FACT_BYTES))
         && ((old_byte & ~prog_data) != 8'h00)) |=> prog_err);

    p_locked_refused_r5: assert property (@(posedge clk) disable iff (rst)
        (prog_req && wr_open && !lock_byte[lock_bit_of(prog_addr[OFS_W-1:0])])
        |=> prog_err);

    p_closed_silent_r7: assert property (@(posedge clk) disable iff (rst)
        (prog_req && !wr_open) |=> !prog_err);

    p_rd_valid_r9: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_valid);

    p_rd_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rd_valid);

    p_err_held_r11: assert property (@(posedge clk) disable iff (rst)
        !prog_req |=> $stable(prog_err));
endmodule

bind sec_otp_guard sec_otp_guard_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_open   (wr_open),
    .prog_req  (prog_req),
    .prog_addr (prog_addr),
    .prog_data (prog_data),
    .rd_req    (rd_req),
    .prog_done (prog_done),
    .prog_err  (prog_err),
    .rd_valid  (rd_valid),
    .old_byte  (old_byte),
    .lock_byte (lock_byte)
);

// File: tb/test_sec_otp_guard.sv
`timescale 1ns/1ps
module test_sec_otp_guard;
    import sec_otp_pkg::*;

    localparam int unsigned ADDR_W = 12;
    localparam logic [127:0] FID = 128'h1122_3344_5566_7788_99AA_BBCC_DDEE_F1F2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_open = 1'b1;
    logic              prog_req = 1'b0;
    logic [ADDR_W-1:0] prog_addr = '0;
    logic [7:0]        prog_data = '0;
    logic              rd_req = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              prog_done, prog_err, rd_valid;
    logic [7:0]        rd_data;

    always #2 clk = ~clk;

    sec_otp_guard #(.ADDR_W(ADDR_W), .FACTORY_ID(FID)) i_sec_otp_guard (
        .clk(clk), .rst(rst), .wr_open(wr_open),
        .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
        .rd_req(rd_req), .rd_addr(rd_addr),
        .prog_done(prog_done), .prog_err(prog_err),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    byte_t mdl [SPACE_BYTES];
    int    vecs = 0;
    int    bad  = 0;
    bit    finished = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input string tag);
        @(negedge clk);
        rd_req  = 1'b1;
        rd_addr = a;
        @(negedge clk);
        rd_req = 1'b0;
        chk({tag, " rd_valid"}, 32'(rd_valid), 32'd1);
        chk({tag, " rd_data"}, 32'(rd_data), 32'(mdl[a[OFS_W-1:0]]));
    endtask

    task automatic pg(input logic [ADDR_W-1:0] a, input byte_t d, input string tag);
        ofs_t             o = a[OFS_W-1:0];
        logic [REG_W-1:0] r = o[OFS_W-1:SUB_W];
        byte_t            lk = mdl[LOCK_BASE + 32'(r) / 8];
        bit               rej = 1'b0;
        if (wr_open) begin
            if (32'(o) < FACT_BYTES && (mdl[o] & ~d) != 8'h00) rej = 1'b1;
            else if (!lk[32'(r) % 8]) rej = 1'b1;
            if (!rej) mdl[o] = mdl[o] & d;
        end
        @(negedge clk);
        prog_req  = 1'b1;
        prog_addr = a;
        prog_data = d;
        @(negedge clk);
        prog_req = 1'b0;
        chk({tag, " prog_done"}, 32'(prog_done), 32'd1);
        chk({tag, " prog_err"}, 32'(prog_err), 32'(rej));
        rd(a, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < int'(SPACE_BYTES); i++)
            mdl[i] = (i < int'(FACT_BYTES)) ? FID[8*i +: 8] : 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: flags after reset, then full content sweep
        chk("R1 prog_done", 32'(prog_done), 32'd0);
        chk("R1 prog_err", 32'(prog_err), 32'd0);
        chk("R1 rd_valid", 32'(rd_valid), 32'd0);
        for (int a = 0; a < int'(SPACE_BYTES); a++) rd(ADDR_W'(a), "R1");

        // R2, R3: repeated AND accumulation at one address
        pg(12'h040, 8'hF0, "R2");
        pg(12'h040, 8'h3C, "R3");
        pg(12'h040, 8'hFF, "R3");
        chk("R3 value", 32'(mdl[12'h040]), 32'h30);
        // R2: sweep over user slices with arithmetic patterns
        for (int a = 32; a < int'(SPACE_BYTES); a += 7)
            pg(ADDR_W'(a), byte_t'((a * 37) ^ 8'h5A), "R2");
        // R9, R11: idle cycle keeps status and emits no strobes
        @(negedge clk);
        chk("R9 idle rd_valid", 32'(rd_valid), 32'd0);
        chk("R2 idle prog_done", 32'(prog_done), 32'd0);
        chk("R11 err held", 32'(prog_err), 32'd0);

        // R4: identifier bytes
        for (int a = 0; a < int'(FACT_BYTES); a++) pg(ADDR_W'(a), 8'hFF, "R4");
        for (int a = 0; a < int'(FACT_BYTES); a++) pg(ADDR_W'(a), 8'h00, "R4");
        pg(12'h000, FID[7:0], "R4");
        @(negedge clk);
        chk("R11 err after pass", 32'(prog_err), 32'd0);

        // R6: spare bytes programmable
        for (int a = 20; a < 32; a++) pg(ADDR_W'(a), 8'hA5, "R6");

        // R5, R6: lock slices 5 and 31, then probe every slice
        pg(12'h010, 8'hDF, "R6");
        pg(12'h013, 8'h7F, "R6");
        pg(12'h0A0, 8'h00, "R5");
        pg(12'h3E0, 8'h00, "R5");
        @(negedge clk);
        chk("R11 err held", 32'(prog_err), 32'd1);
        pg(12'h0C0, 8'h0F, "R5");
        for (int s = 1; s < int'(NUM_REGIONS); s++)
            pg(ADDR_W'(s * 32 + 3), 8'h81, "R5");

        // R8: wrap on both ports
        pg(12'hC48, 8'h0F, "R8");
        rd(12'h448, "R8");
        rd(12'h848, "R8");

        // R7, R10: closed programming
        wr_open = 1'b0;
        pg(12'h060, 8'h00, "R7");
        pg(12'h005, 8'h00, "R10");
        pg(12'h0A1, 8'h00, "R10");
        wr_open = 1'b1;
        pg(12'h060, 8'h0F, "R7");

        // R5: lock slice 0, which then guards the lock field itself
        pg(12'h010, 8'hDE, "R5");
        pg(12'h014, 8'h00, "R5");
        pg(12'h011, 8'h00, "R5");
        pg(12'h020, 8'h00, "R5");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end
endmodule